// File: doc/BRIEF.md
# Buzzer PWM Driver with Square-Wave Gating

The block drives a one-bit buzzer pin with a pulse-width-modulated carrier. A carrier divider sets the period in clock cycles, and an 8-bit duty value sets how much of each period the pin is high, which controls the loudness. A period value and a duty value are captured only when a carrier period begins, so a register change in the middle of a period never cuts a pulse short.

When gating is switched on, a second, independent divider produces a 50% square wave. The carrier is ANDed with that wave to give an interrupted or warbling sound. The pin is held low while the block is disabled or while the operating mode input selects the FM mode. Both dividers restart from the start of a period when the block becomes active again.

Top module: `buzz_pwm`

## Requirements
- R1: With carrier divider value D, the carrier period is D+1 clock cycles. `buzz_o` is registered and follows the internal state one cycle after a clock edge.
- R2: In each carrier period the pin is high for the first floor((D+1)*duty/256) cycles and low for the remaining cycles (gating off).
- R3: A duty value of 0 holds the pin low.
- R4: A duty value of 255 never holds the pin high for a whole period: at least the last cycle of every period is low.
- R5: A change of the divider value or the duty value takes effect only at the next period start. A period start is the cycle after the last count, or any cycle in which the block is inactive.
- R6: With `gate_en_i` high, the output is the carrier ANDed with a square wave. Each half of that wave lasts G+1 cycles, where G is `gate_div_i`. The wave starts high whenever gating is (re)started, and G is captured at each toggle.
- R7: With `gate_en_i` low, the carrier reaches the pin unchanged and the gating divider is held at its start state.
- R8: `enable_i` low drives the pin low and restarts both dividers.
- R9: `mode_i` = 2'b11 (FM) drives the pin low and restarts both dividers, as in R8. The codes 2'b00, 2'b01 and 2'b10 operate normally.
- R10: While `rst_ni` is low, and in the first cycle after reset, the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable |
| mode_i | input | 2 | Operating mode, 2'b11 = FM (output off) |
| car_div_i | input | 16 | Carrier period minus one, in cycles |
| duty_i | input | 8 | High-time fraction, in units of 1/256 |
| gate_en_i | input | 1 | Enables gating by the square wave |
| gate_div_i | input | 16 | Square-wave half period minus one, in cycles |
| buzz_o | output | 1 | Buzzer drive |

## Verification
Two events can fall in the same cycle: a carrier period boundary, where new divider and duty values are captured, and a toggle of the gating square wave or a register rewrite. Stimulus rewrites the divider, duty, gating and enable inputs at random on many cycles. Such writes therefore land on the last count of a period as well as in the middle of one, and they coincide with gating edges. A cycle-exact reference model in the bench judges every cycle. It decides from the requirements whether each write was captured at that boundary or must wait a full period.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
  localparam int unsigned DIV_W  = 16;
  localparam int unsigned DUTY_W = 8;

  typedef enum logic [1:0] {
    MODE_VOICE = 2'b00,
    MODE_TONE  = 2'b01,
    MODE_AUDIO = 2'b10,
    MODE_FM    = 2'b11
  } buzz_mode_e;
endpackage

// File: rtl/buzz_carrier.sv
module buzz_carrier #(
  parameter int unsigned DIV_W  = buzz_pkg::DIV_W,
  parameter int unsigned DUTY_W = buzz_pkg::DUTY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o,
  output logic              last_o,
  output logic [DIV_W-1:0]  cnt_o,
  output logic [DIV_W-1:0]  per_o,
  output logic [DIV_W:0]    hi_o
);
  localparam int unsigned HI_W = DIV_W + 1;
  localparam int unsigned PR_W = HI_W + DUTY_W;

  logic [DIV_W-1:0] cnt_q, per_q;
  logic [HI_W-1:0]  hi_q, hi_d, span;
  logic [PR_W-1:0]  prod;
  logic             last;

  // high time = (div+1) * duty / 2^DUTY_W, always below the period
  assign span = {1'b0, div_i} + HI_W'(1);
  assign prod = PR_W'(span) * PR_W'(duty_i);
  assign hi_d = prod[PR_W-1:DUTY_W];
  assign last = (cnt_q == per_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      hi_q  <= '0;
    end else if (!run_i || last) begin
      cnt_q <= '0;
      per_q <= div_i;
      hi_q  <= hi_d;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign pwm_o  = ({1'b0, cnt_q} < hi_q);
  assign last_o = last;
  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign hi_o   = hi_q;
endmodule

// File: rtl/buzz_square.sv
module buzz_square #(
  parameter int unsigned DIV_W = buzz_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             lvl_o
);
  logic [DIV_W-1:0] cnt_q, per_q;
  logic             lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      lvl_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      per_q <= div_i;
      lvl_q <= 1'b1;
    end else if (cnt_q == per_q) begin
      cnt_q <= '0;
      per_q <= div_i;
      lvl_q <= ~lvl_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/buzz_pwm.sv
module buzz_pwm #(
  parameter int unsigned DIV_W  = buzz_pkg::DIV_W,
  parameter int unsigned DUTY_W = buzz_pkg::DUTY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [1:0]        mode_i,
  input  logic [DIV_W-1:0]  car_div_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              gate_en_i,
  input  logic [DIV_W-1:0]  gate_div_i,
  output logic              buzz_o
);
  import buzz_pkg::*;

  logic             active, gate_run, pwm, gate_lvl, car_last, buzz_d, buzz_q;
  logic [DIV_W-1:0] car_cnt, car_per;
  logic [DIV_W:0]   car_hi;

  assign active   = enable_i && (buzz_mode_e'(mode_i) != MODE_FM);
  assign gate_run = active && gate_en_i;

  buzz_carrier #(.DIV_W(DIV_W), .DUTY_W(DUTY_W)) i_carrier (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .div_i  (car_div_i),
    .duty_i (duty_i),
    .pwm_o  (pwm),
    .last_o (car_last),
    .cnt_o  (car_cnt),
    .per_o  (car_per),
    .hi_o   (car_hi)
  );

  buzz_square #(.DIV_W(DIV_W)) i_square (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (gate_run),
    .div_i  (gate_div_i),
    .lvl_o  (gate_lvl)
  );

  assign buzz_d = active && pwm && (!gate_en_i || gate_lvl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) buzz_q <= 1'b0;
    else         buzz_q <= buzz_d;
  end

  assign buzz_o = buzz_q;
endmodule

// File: rtl/buzz_pwm_chk.sv
module buzz_pwm_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic [1:0]       mode_i,
  input logic             gate_run,
  input logic             gate_lvl,
  input logic             pwm,
  input logic             car_last,
  input logic [DIV_W-1:0] car_cnt,
  input logic [DIV_W-1:0] car_per,
  input logic [DIV_W:0]   car_hi,
  input logic             buzz_o
);
  AST_RESET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !buzz_o); // R10
  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(enable_i) |-> !buzz_o); // R8
  AST_FM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'b11) |-> !buzz_o); // R9
  AST_LAST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    car_last |-> !pwm); // R4
  AST_MID_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_cnt != '0) |-> ($stable(car_hi) && $stable(car_per))); // R5
  AST_GATE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(gate_run && !gate_lvl) |-> !buzz_o); // R6
  AST_DUTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_hi == '0) |-> !pwm); // R3
endmodule

bind buzz_pwm buzz_pwm_chk #(.DIV_W(DIV_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .mode_i   (mode_i),
  .gate_run (gate_run),
  .gate_lvl (gate_lvl),
  .pwm      (pwm),
  .car_last (car_last),
  .car_cnt  (car_cnt),
  .car_per  (car_per),
  .car_hi   (car_hi),
  .buzz_o   (buzz_o)
);

// File: tb/test_buzz_pwm.sv
`timescale 1ns/1ps
module test_buzz_pwm;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [15:0] car_div_i = '0;
  logic [7:0]  duty_i = '0;
  logic        gate_en_i = 1'b0;
  logic [15:0] gate_div_i = '0;
  logic        buzz_o;

  int unsigned total = 0, bad = 0;
  string       tag = "R10";

  // reference model state
  int unsigned m_cnt, m_per, m_hi, g_cnt, g_per;
  bit          g_lvl, exp_q;

  always #2.5 clk_i = ~clk_i;

  buzz_pwm i_buzz_pwm (.*);

  function automatic int unsigned high_time(int unsigned div, int unsigned duty);
    return ((div + 1) * duty) / 256;
  endfunction

  function automatic bit is_active(bit en, logic [1:0] md);
    return en && (md != 2'b11);
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_per = 0; m_hi = 0; g_cnt = 0; g_per = 0; g_lvl = 1; exp_q = 0;
  endtask

  task automatic model_step();
    bit act, grun;
    act  = is_active(enable_i, mode_i);
    grun = act && gate_en_i;
    exp_q = act && (m_cnt < m_hi) && (!gate_en_i || g_lvl);
    if (!act || m_cnt == m_per) begin
      m_cnt = 0; m_per = car_div_i; m_hi = high_time(car_div_i, duty_i);
    end else m_cnt++;
    if (!grun) begin
      g_cnt = 0; g_per = gate_div_i; g_lvl = 1;
    end else if (g_cnt == g_per) begin
      g_cnt = 0; g_per = gate_div_i; g_lvl = ~g_lvl;
    end else g_cnt++;
  endtask

  task automatic check(bit got, bit exp, string t);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s t=%0t buzz_o=%0b expected=%0b", t, $time, got, exp);
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk_i);
    check(buzz_o, exp_q, tag);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    int hi_n, lo_n;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk_i);
    check(buzz_o, 1'b0, "R10 in reset");
    rst_ni = 1'b1;
    tag = "R10";
    tick();

    // R1 R2: fixed carrier, no gating
    tag = "R1 R2 div=9 duty=128";
    enable_i = 1; car_div_i = 9; duty_i = 128;
    run(60);
    hi_n = 0;
    for (int i = 0; i < 10; i++) begin tick(); hi_n += buzz_o; end
    total++;
    if (hi_n != 5) begin bad++; $display("FAIL R2 high=%0d expected=5", hi_n); end

    // R5: rewrite in mid-period
    tag = "R5 mid-period rewrite";
    run(3);
    car_div_i = 3; duty_i = 64;
    run(40);

    // R3: zero duty
    tag = "R3 duty 0";
    duty_i = 0; car_div_i = 5;
    run(10);
    hi_n = 0;
    for (int i = 0; i < 64; i++) begin tick(); hi_n += buzz_o; end
    total++;
    if (hi_n != 0) begin bad++; $display("FAIL R3 high=%0d expected=0", hi_n); end

    // R4: full duty keeps one low cycle
    tag = "R4 duty 255";
    duty_i = 255; car_div_i = 7;
    run(10);
    lo_n = 0;
    for (int i = 0; i < 64; i++) begin tick(); lo_n += !buzz_o; end
    total++;
    if (lo_n != 8) begin bad++; $display("FAIL R4 low=%0d expected=8", lo_n); end

    // R6: gating
    tag = "R6 gating";
    duty_i = 128; car_div_i = 1; gate_en_i = 1; gate_div_i = 6;
    run(80);
    // R7: gating off
    tag = "R7 no gating";
    gate_en_i = 0;
    run(40);

    // R8: disabled
    tag = "R8 disabled";
    enable_i = 0;
    for (int i = 0; i < 20; i++) begin tick(); check(buzz_o, 1'b0, "R8 forced low"); end
    enable_i = 1;
    run(20);

    // R9: FM mode forces low, other modes run
    tag = "R9 fm";
    mode_i = 2'b11;
    for (int i = 0; i < 20; i++) begin tick(); check(buzz_o, 1'b0, "R9 forced low"); end
    for (int m = 0; m < 3; m++) begin
      tag = "R9 normal mode";
      mode_i = 2'(m);
      run(20);
    end

    // random mix, writes land anywhere in a period
    tag = "R1 R2 R5 R6 R7 random";
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 9) == 0) car_div_i = 16'($urandom_range(0, 30));
      if ($urandom_range(0, 9) == 0) duty_i = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 29) == 0) gate_en_i = ~gate_en_i;
      if ($urandom_range(0, 14) == 0) gate_div_i = 16'($urandom_range(0, 20));
      if ($urandom_range(0, 99) == 0) enable_i = ~enable_i;
      if ($urandom_range(0, 99) == 0) mode_i = 2'($urandom_range(0, 3));
      tick();
    end

    // R10: reset in the middle of activity
    tag = "R10 mid reset";
    enable_i = 1; mode_i = 0; car_div_i = 4; duty_i = 200; gate_en_i = 0;
    run(7);
    rst_ni = 0;
    model_reset();
    #1 check(buzz_o, 1'b0, "R10 async");
    @(negedge clk_i);
    rst_ni = 1;
    run(40);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule